// File: doc/BRIEF.md
# Manchester Ethernet Frame Transmitter with Appended CRC

This block sends one Ethernet frame at a time onto a differential transmit pair using Manchester coding at the 10 Mb/s bit rate. Frame bytes arrive from the destination address through the end of the payload on a byte stream with valid, ready and last. The block opens the frame with a fixed preamble and start delimiter. It then streams the supplied bytes while folding each one into a running CRC-32. After the data it appends the complemented CRC. It closes with a positive-high end-of-transmission idle and a one-cycle completion interrupt.

A neighbouring link-pulse generator shares the pair. This block waits while that generator reports it is busy. It raises `tx_active` for the whole transmission so that the generator can hold off in turn. The line timing is set by two parameters: the clock cycles per half-bit and the clock cycles of the end idle. At a 100 MHz clock the defaults give 50 ns half-bits and a 250 ns idle.

Top module: `tx_eth_serializer`

## Requirements
- R1: After reset, `tx_p`, `tx_n`, `tx_active`, `tx_done_irq` and `s_ready` are all low.
- R2: A transmission starts only on a cycle where `s_valid` is high and `link_busy` is low. While `link_busy` is high, `tx_active`, `tx_p` and `tx_n` stay low.
- R3: The frame opens with PRE_BYTES (default 7) bytes of 0x55, then one 0xD5. Every byte on the line goes least significant bit first.
- R4: Each bit lasts 2*HALF_CYC clock cycles. A 1 puts `tx_p` low and then high; a 0 puts `tx_p` high and then low. While bits are being sent, `tx_n` is always the complement of `tx_p`.
- R5: Data bytes are taken one per byte time, in arrival order, and go out directly after the delimiter. `s_ready` is high only in the last cycle of the byte before a data byte is due. A byte taken with `s_last` high is the final data byte.
- R6: Directly after the data, four bytes go out, low byte first. They are the CRC-32 of the data bytes: reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF, result complemented.
- R7: If `s_valid` is low when a data byte is due, the data section ends there. The check sequence covers only the bytes already taken; with none taken it is 0x00000000.
- R8: After the last check bit, `tx_p` is high and `tx_n` low for END_IDLE_CYC cycles. Then both lines are low.
- R9: `tx_done_irq` is high for exactly one cycle, the cycle right after the end idle. `tx_active` is high from the first preamble half-bit through the end idle and is low in the interrupt cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_data | input | 8 | Frame byte from the source |
| s_valid | input | 1 | Source byte available |
| s_last | input | 1 | Current byte is the last of the frame |
| s_ready | output | 1 | Byte is taken on this edge if valid |
| link_busy | input | 1 | Link-pulse generator is driving the pair |
| tx_p | output | 1 | Positive line of the pair |
| tx_n | output | 1 | Negative line of the pair |
| tx_active | output | 1 | Transmission in progress |
| tx_done_irq | output | 1 | One-cycle completion pulse |

## Verification
The first preamble half-bit is on the lines in the cycle right after the edge that sees `s_valid` high with `link_busy` low. That is also the first cycle in which `tx_active` reads high. Counting from that cycle, half-bit s of the frame occupies cycles s*HALF_CYC through s*HALF_CYC+HALF_CYC-1. For a frame of B bytes, the end idle starts at cycle 16*B*HALF_CYC. The interrupt comes END_IDLE_CYC cycles after that. The bench finds the first cycle in which `tx_active` reads high and counts falling edges from there. It samples every half-bit, the idle and the interrupt in exactly those cycles. Meanwhile a source thread hands over a byte only on the edge that follows a sampled `s_ready`.

// File: rtl/tx_eth_pkg.sv
package tx_eth_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_FCS,
    ST_ENDIDLE,
    ST_IRQ
  } tx_state_e;

  localparam logic [7:0]  PRE_BYTE      = 8'h55;
  localparam logic [7:0]  SFD_BYTE      = 8'hD5;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT      = 32'hFFFFFFFF;

  // Reflected CRC-32 update over one byte, least significant bit first.
  function automatic logic [31:0] crc32_byte(input logic [31:0] c_in,
                                             input logic [7:0]  d);
    logic [31:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_REFL;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/tx_crc32.sv
module tx_crc32
  import tx_eth_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  data,
  output logic [31:0] crc
);

  always_ff @(posedge clk) begin
    if (rst || init) crc <= CRC_INIT;
    else if (en)     crc <= crc32_byte(crc, data);
  end

  // R6: the register only moves on an init or an accepted byte
  a_r6_crc_hold: assert property (@(posedge clk) disable iff (rst)
    (!init && !en) |=> $stable(crc));

endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int HALF_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic mid,
  output logic bit_end
);

  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [HW-1:0] HLAST = HW'(HALF_CYC - 1);

  logic [HW-1:0] hcnt;
  logic          second;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      hcnt   <= '0;
      second <= 1'b0;
    end else if (run) begin
      if (hcnt == HLAST) begin
        hcnt   <= '0;
        second <= ~second;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  assign mid     = run && !second && (hcnt == HLAST);
  assign bit_end = run &&  second && (hcnt == HLAST);

  // R4: the half-bit counter never passes its limit
  a_r4_half_bound: assert property (@(posedge clk) disable iff (rst)
    hcnt <= HLAST);

  // R4: every bit end is preceded by a mid-bit point, one half earlier
  a_r4_mid_then_end: assert property (@(posedge clk) disable iff (rst)
    (mid && !restart) |=> !bit_end || (HALF_CYC == 1));

endmodule

// File: rtl/tx_eth_serializer.sv
module tx_eth_serializer
  import tx_eth_pkg::*;
#(
  parameter int HALF_CYC     = 5,
  parameter int END_IDLE_CYC = 25,
  parameter int PRE_BYTES    = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  input  logic       link_busy,
  output logic       tx_p,
  output logic       tx_n,
  output logic       tx_active,
  output logic       tx_done_irq
);

  localparam int BW = $clog2(PRE_BYTES + 5);
  localparam int IW = (END_IDLE_CYC > 1) ? $clog2(END_IDLE_CYC) : 1;
  localparam logic [BW-1:0] SFD_IDX  = BW'(PRE_BYTES);
  localparam logic [BW-1:0] FCS_LAST = BW'(3);
  localparam logic [IW-1:0] ILAST    = IW'(END_IDLE_CYC - 1);

  tx_state_e     st;
  logic [7:0]    shreg;
  logic [2:0]    bitn;
  logic [BW-1:0] bytn;
  logic [IW-1:0] icnt;
  logic [23:0]   fcs_rem;
  logic          last_seen;
  logic [31:0]   crc;
  logic          mid, bit_end, running, start, take;

  logic          more, load_fcs;
  logic [7:0]    nxt_byte;
  tx_state_e     nxt_st;
  logic [BW-1:0] nxt_bytn;

  assign running = (st == ST_PRE) || (st == ST_DATA) || (st == ST_FCS);
  assign start   = (st == ST_IDLE) && s_valid && !link_busy;
  assign s_ready = bit_end && (bitn == 3'd7) &&
                   (((st == ST_PRE) && (bytn == SFD_IDX)) ||
                    ((st == ST_DATA) && !last_seen));
  assign take    = s_ready && s_valid;

  tx_bit_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (start),
    .run     (running),
    .mid     (mid),
    .bit_end (bit_end)
  );

  tx_crc32 u_crc (
    .clk  (clk),
    .rst  (rst),
    .init (start),
    .en   (take),
    .data (s_data),
    .crc  (crc)
  );

  // Choice of the byte that follows a completed byte
  always_comb begin
    more     = 1'b0;
    load_fcs = 1'b0;
    nxt_byte = 8'h00;
    nxt_st   = st;
    nxt_bytn = bytn + 1'b1;
    unique case (st)
      ST_PRE: begin
        if (bytn + 1'b1 < SFD_IDX) begin
          more = 1'b1; nxt_byte = PRE_BYTE;
        end else if (bytn + 1'b1 == SFD_IDX) begin
          more = 1'b1; nxt_byte = SFD_BYTE;
        end else if (s_valid) begin
          more = 1'b1; nxt_byte = s_data; nxt_st = ST_DATA;
        end else begin
          more = 1'b1; load_fcs = 1'b1; nxt_byte = ~crc[7:0];
          nxt_st = ST_FCS; nxt_bytn = '0;
        end
      end
      ST_DATA: begin
        if (!last_seen && s_valid) begin
          more = 1'b1; nxt_byte = s_data;
        end else begin
          more = 1'b1; load_fcs = 1'b1; nxt_byte = ~crc[7:0];
          nxt_st = ST_FCS; nxt_bytn = '0;
        end
      end
      ST_FCS: begin
        if (bytn != FCS_LAST) begin
          more = 1'b1; nxt_byte = fcs_rem[7:0];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      shreg       <= '0;
      bitn        <= '0;
      bytn        <= '0;
      icnt        <= '0;
      fcs_rem     <= '0;
      last_seen   <= 1'b0;
      tx_p        <= 1'b0;
      tx_n        <= 1'b0;
      tx_active   <= 1'b0;
      tx_done_irq <= 1'b0;
    end else begin
      tx_done_irq <= 1'b0;
      if (take && s_last) last_seen <= 1'b1;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            st        <= ST_PRE;
            shreg     <= PRE_BYTE;
            bitn      <= '0;
            bytn      <= '0;
            last_seen <= 1'b0;
            tx_p      <= ~PRE_BYTE[0];
            tx_n      <=  PRE_BYTE[0];
            tx_active <= 1'b1;
          end
        end
        ST_PRE, ST_DATA, ST_FCS: begin
          if (mid) begin
            tx_p <=  shreg[0];
            tx_n <= ~shreg[0];
          end else if (bit_end) begin
            if (bitn != 3'd7) begin
              shreg <= shreg >> 1;
              bitn  <= bitn + 1'b1;
              tx_p  <= ~shreg[1];
              tx_n  <=  shreg[1];
            end else if (more) begin
              shreg <= nxt_byte;
              bitn  <= '0;
              bytn  <= nxt_bytn;
              st    <= nxt_st;
              tx_p  <= ~nxt_byte[0];
              tx_n  <=  nxt_byte[0];
              if (load_fcs)          fcs_rem <= ~crc[31:8];
              else if (st == ST_FCS) fcs_rem <= fcs_rem >> 8;
            end else begin
              st   <= ST_ENDIDLE;
              icnt <= '0;
              tx_p <= 1'b1;
              tx_n <= 1'b0;
            end
          end
        end
        ST_ENDIDLE: begin
          if (icnt == ILAST) begin
            st          <= ST_IRQ;
            tx_p        <= 1'b0;
            tx_n        <= 1'b0;
            tx_active   <= 1'b0;
            tx_done_irq <= 1'b1;
          end else begin
            icnt <= icnt + 1'b1;
          end
        end
        ST_IRQ: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: differential lines stay complementary while bits are sent
  a_r4_complement: assert property (@(posedge clk) disable iff (rst)
    running |-> (tx_n == !tx_p));

  // R2: no transmission begins while the link pulse is busy
  a_r2_hold_off: assert property (@(posedge clk) disable iff (rst)
    (!tx_active && link_busy) |=> !tx_active);

  // R5: the source is only asked for a byte at a bit boundary
  a_r5_ready_edge: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> bit_end);

  // R8: end idle drives positive-high
  a_r8_idle_level: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ENDIDLE) |-> (tx_p && !tx_n));

  // R9: interrupt is a single cycle and never overlaps tx_active
  a_r9_irq_single: assert property (@(posedge clk) disable iff (rst)
    tx_done_irq |=> !tx_done_irq);
  a_r9_irq_excl: assert property (@(posedge clk) disable iff (rst)
    !(tx_done_irq && tx_active));

endmodule

// File: tb/sim_tx_eth_serializer.sv
`timescale 1ns/1ps
module sim_tx_eth_serializer;
  localparam int HALF = 2;
  localparam int IDLE = 5;
  localparam int PRE  = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_valid_r = 1'b0;
  logic use_last = 1'b0;
  logic link_busy = 1'b0;
  logic [7:0] fr [0:299];
  int   flen = 0, stop_at = -1, idx = 0;
  logic [7:0] s_data;
  logic s_last, s_ready, tx_p, tx_n, tx_active, tx_done_irq;
  int   n_cmp = 0, n_bad = 0;
  bit   done_flag;

  always #2 clk = ~clk;

  assign s_data = fr[(idx < 300) ? idx : 0];
  assign s_last = use_last && (idx == flen - 1);

  tx_eth_serializer #(.HALF_CYC(HALF), .END_IDLE_CYC(IDLE), .PRE_BYTES(PRE)) u0 (
    .clk(clk), .rst(rst), .s_data(s_data), .s_valid(s_valid_r), .s_last(s_last),
    .s_ready(s_ready), .link_busy(link_busy), .tx_p(tx_p), .tx_n(tx_n),
    .tx_active(tx_active), .tx_done_irq(tx_done_irq));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        c = ((c ^ 32'(fr[i][b])) & 1) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return ~c;
  endfunction

  task automatic feeder();
    idx = 0;
    s_valid_r = 1'b1;
    if (stop_at == 0) begin
      while (!tx_active) @(negedge clk);
      s_valid_r = 1'b0;
    end
    while (!done_flag) begin
      @(negedge clk);
      if (s_ready && s_valid_r) begin
        @(posedge clk);
        #1;
        idx++;
        if (idx >= flen || idx == stop_at) s_valid_r = 1'b0;
      end
    end
    s_valid_r = 1'b0;
  endtask

  task automatic decoder(input int nd, input string dtag);
    logic [7:0] exp_b [0:319];
    int nb = PRE + 1 + nd + 4;
    logic [31:0] fcs;
    bit man_ok = 1'b1, idle_ok = 1'b1;
    int wait_n = 0;
    fcs = ref_crc(nd);
    for (int i = 0; i < PRE; i++) exp_b[i] = 8'h55;
    exp_b[PRE] = 8'hD5;
    for (int i = 0; i < nd; i++) exp_b[PRE + 1 + i] = fr[i];
    for (int i = 0; i < 4; i++) exp_b[PRE + 1 + nd + i] = fcs[8*i +: 8];
    while (!tx_active && wait_n < 5000) begin @(negedge clk); wait_n++; end
    for (int b = 0; b < nb; b++) begin
      logic [7:0] got = '0;
      for (int k = 0; k < 8; k++) begin
        logic p1, n1, p2, n2;
        p1 = tx_p; n1 = tx_n;
        repeat (HALF) @(negedge clk);
        p2 = tx_p; n2 = tx_n;
        repeat (HALF) @(negedge clk);
        got[k] = p2;
        if (p1 == p2 || n1 == p1 || n2 == p2 || !tx_active) man_ok = 1'b0;
      end
      if (b <= PRE)          chk("R3", "preamble/SFD byte", 32'(got), 32'(exp_b[b]));
      else if (b <= PRE + nd) chk("R5", "data byte", 32'(got), 32'(exp_b[b]));
      else                   chk(dtag, "check byte", 32'(got), 32'(exp_b[b]));
    end
    chk("R4", "manchester coding", 32'(man_ok), 32'd1);
    for (int i = 0; i < IDLE; i++) begin
      if (!(tx_p && !tx_n && tx_active && !tx_done_irq)) idle_ok = 1'b0;
      @(negedge clk);
    end
    chk("R8", "end idle level", 32'(idle_ok), 32'd1);
    chk("R9", "irq/active/lines at end", {28'd0, tx_done_irq, tx_active, tx_p, tx_n}, 32'h8);
    @(negedge clk);
    chk("R9", "irq single cycle", 32'(tx_done_irq), 32'd0);
    done_flag = 1'b1;
  endtask

  task automatic run_frame(input int n, input int stop, input bit lst, input string dtag);
    int nd;
    flen = n; stop_at = stop; use_last = lst; done_flag = 1'b0;
    nd = (stop >= 0) ? stop : n;
    fork
      feeder();
      decoder(nd, dtag);
    join
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 300; i++) fr[i] = 8'(i);
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", {27'd0, tx_p, tx_n, tx_active, tx_done_irq, s_ready}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "outputs after reset", {27'd0, tx_p, tx_n, tx_active, tx_done_irq, s_ready}, 32'd0);

    // R2: hold off while link pulse is busy
    begin
      bit quiet = 1'b1;
      link_busy = 1'b1;
      s_valid_r = 1'b1;
      repeat (40) begin
        @(negedge clk);
        if (tx_active || tx_p || tx_n) quiet = 1'b0;
      end
      chk("R2", "no start while busy", 32'(quiet), 32'd1);
      link_busy = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R2", "start after busy clears", 32'(tx_active), 32'd1);
      s_valid_r = 1'b0;
      rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    end

    // small frame ended by last
    for (int i = 0; i < 6; i++) fr[i] = 8'hA0 + 8'(i);
    run_frame(6, -1, 1'b1, "R6");
    // single-byte frame
    fr[0] = 8'h00;
    run_frame(1, -1, 1'b1, "R6");
    // every byte value once
    for (int i = 0; i < 256; i++) fr[i] = 8'(255 - i);
    run_frame(256, -1, 1'b1, "R6");
    // underrun after 4 bytes, no last ever
    for (int i = 0; i < 10; i++) fr[i] = (i % 2) ? 8'hFF : 8'h00;
    run_frame(10, 4, 1'b0, "R7");
    // no data at all
    run_frame(10, 0, 1'b0, "R7");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule